// File: doc/BRIEF.md
# Half-Word Pairing Host Bus Front End

This block sits between a processor's data bus and an internal 32-bit register and FIFO port. When the host bus is 16 bits wide, every internal 32-bit word takes two half-word accesses. The block pairs them into one internal access. On a write, the first half is held in a staging register. When the other half of the same word arrives, the merged word is committed with a single internal write strobe. On a read, the first half-access fetches and latches the whole word. The second half is then served from that latch, so both halves come from one internal read.

The halves may arrive in either order. A repeated access to the same half cancels a pending write pair, or restarts a read pair. A change of the word address (address bits 2 and up) drops whatever half is pending, and the new access begins a fresh pair. A 32-bit swap configuration value that is exactly all-ones reverses which address half maps to the low internal word. Any other value, or 32-bit bus mode, gives the default mapping. In 32-bit mode each access moves the full word at once.

The controller has three states. ST_IDLE means no half is pending. ST_WR_HALF means one write half is staged. ST_RD_HALF means a word is latched and one half has been served.

Transitions:
- From ST_IDLE, a 16-bit write goes to ST_WR_HALF and a 16-bit read goes to ST_RD_HALF.
- In ST_WR_HALF or ST_RD_HALF, a 16-bit access of the same kind to the opposite half of the same word completes the pair and returns to ST_IDLE.
- A same-kind access to the same half of the same word also returns to ST_IDLE. For a write this is a discard; for a read it is an invalid read.
- A same-kind access to a different word restarts the pair in the same state.
- An access of the other kind moves to that kind's half state as a fresh pair.
- Any 32-bit-mode access returns to ST_IDLE.
- With no access, the state holds.

Top module: `hbw_word_pair`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, iwr, ird and hrdata_oe are 0 and hrdata is 0.
- R2: In 16-bit mode (mode32=0), two writes to opposite halves of the same word, in either order, produce exactly one iwr. It comes in the cycle of the second write. iaddr is the word address and iwdata is {high half, low half}. The first write produces no iwr.
- R3: In 16-bit mode, a second write to the same half of the same word commits nothing. The pending half is discarded, and the next write starts a new pair.
- R4: In 16-bit mode, an access to a different word address, or an access of the other kind (read versus write), drops any pending half without a commit. That access then starts a new pair.
- R5: In 16-bit mode, the first read of a pair asserts ird for one cycle and latches irdata. The read that completes the pair asserts no ird and returns its half from the latch, even if irdata has changed in between.
- R6: In 16-bit mode, a second read of the same half of the same word asserts no ird and returns 0x0000. The next read starts a new pair and asserts ird.
- R7: In 16-bit mode, the internal half selected is high when haddr[1] XOR swap is 1, where swap is 1 only when swap_cfg equals 0xFFFFFFFF.
- R8: In 32-bit mode (mode32=1), each write asserts iwr with iwdata = hwdata, and each read asserts ird and returns the full irdata. swap_cfg has no effect in this mode.
- R9: Read data appears on hrdata one cycle after the read access. hrdata_oe is 2'b01 for a 16-bit read, with hrdata[31:16]=0, and 2'b11 for a 32-bit read. In every other cycle hrdata_oe is 2'b00, and hrdata_oe[1] is never set in 16-bit mode.
- R10: A cycle with hcs low asserts neither iwr nor ird and keeps any pending half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 = 32-bit host bus, 0 = 16-bit host bus |
| swap_cfg | input | 32 | Word-swap configuration value; all-ones enables swap |
| hcs | input | 1 | Host chip select; one access per cycle while high |
| hwr | input | 1 | Host write strobe (takes precedence over hrd) |
| hrd | input | 1 | Host read strobe |
| haddr | input | ADDR_W-1 | Host byte address bits ADDR_W-1 down to 1 |
| hwdata | input | 32 | Host write data; bits 15:0 only in 16-bit mode |
| hrdata | output | 32 | Host read data, registered |
| hrdata_oe | output | 2 | Drive enables for hrdata[15:0] (bit 0) and hrdata[31:16] (bit 1) |
| iwr | output | 1 | Internal write commit strobe |
| ird | output | 1 | Internal read request strobe |
| iaddr | output | ADDR_W-2 | Internal word address |
| iwdata | output | 32 | Internal write data |
| irdata | input | 32 | Internal read data, valid in the cycle ird is high |

## Verification
The assertions watch, on every cycle, several rules that follow from the handshake alone:
- iwr and ird are never high together.
- A deselected cycle is quiet.
- A 16-bit commit only happens from the staged-write state and always returns the controller to ST_IDLE.
- Drive enables only follow a read, and the upper lanes are only enabled after a 32-bit read.

Which half-pairs merge into which word is left to the bench's scenarios, because it depends on the sequence of accesses. So are the discard of a repeated write half, the restart after a repeated read half, the serving of a stale-safe half from the latch, and the swap decode. The bench's reference model checks all of these against the ports cycle by cycle.

// File: rtl/hbw_pkg.sv
package hbw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HALF = 2'd1,
        ST_RD_HALF = 2'd2
    } hbw_state_e;
endpackage

// File: rtl/hbw_lane_map.sv
module hbw_lane_map #(
    parameter int DATA_W = 32
) (
    input  logic              mode32,
    input  logic [DATA_W-1:0] swap_cfg,
    input  logic              addr_half,
    output logic              phys_hi
);
    logic swap_on;

    always_comb begin
        swap_on = !mode32 && (swap_cfg == {DATA_W{1'b1}});
        phys_hi = addr_half ^ swap_on;
    end
endmodule

// File: rtl/hbw_write_stage.sv
module hbw_write_stage #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              in_hi,
    input  logic [HALF_W-1:0] din,
    output logic [DATA_W-1:0] merged
);
    logic [HALF_W-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (load) begin
            stage_q <= din;
        end
    end

    always_comb begin
        merged = in_hi ? {din, stage_q} : {stage_q, din};
    end
endmodule

// File: rtl/hbw_read_latch.sv
module hbw_read_latch #(
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              sel_hi,
    output logic [HALF_W-1:0] half
);
    logic [DATA_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= din;
        end
    end

    always_comb begin
        half = sel_hi ? word_q[DATA_W-1:HALF_W] : word_q[HALF_W-1:0];
    end
endmodule

// File: rtl/hbw_word_pair.sv
module hbw_word_pair #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int HALF_W = DATA_W / 2,
    localparam int WADR_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode32,
    input  logic [DATA_W-1:0] swap_cfg,
    input  logic              hcs,
    input  logic              hwr,
    input  logic              hrd,
    input  logic [ADDR_W-1:1] haddr,
    input  logic [DATA_W-1:0] hwdata,
    output logic [DATA_W-1:0] hrdata,
    output logic [1:0]        hrdata_oe,
    output logic              iwr,
    output logic              ird,
    output logic [WADR_W-1:0] iaddr,
    output logic [DATA_W-1:0] iwdata,
    input  logic [DATA_W-1:0] irdata
);
    import hbw_pkg::*;

    hbw_state_e st, st_nxt;

    logic              wr16, wr32, rd16, rd32;
    logic              phys_hi, same_word, opp_half;
    logic [WADR_W-1:0] pend_addr;
    logic              pend_hi;
    logic              pend_load, stage_load, latch_load;
    logic              serve_latch, serve_bad;
    logic [DATA_W-1:0] merged;
    logic [HALF_W-1:0] latch_half, fresh_half;

    always_comb begin
        wr32      = hcs && hwr && mode32;
        wr16      = hcs && hwr && !mode32;
        rd32      = hcs && hrd && !hwr && mode32;
        rd16      = hcs && hrd && !hwr && !mode32;
        same_word = (pend_addr == haddr[ADDR_W-1:2]);
        opp_half  = (pend_hi != phys_hi);
    end

    hbw_lane_map #(.DATA_W(DATA_W)) u_map (
        .mode32    (mode32),
        .swap_cfg  (swap_cfg),
        .addr_half (haddr[1]),
        .phys_hi   (phys_hi)
    );

    hbw_write_stage #(.DATA_W(DATA_W)) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (stage_load),
        .in_hi  (phys_hi),
        .din    (hwdata[HALF_W-1:0]),
        .merged (merged)
    );

    hbw_read_latch #(.DATA_W(DATA_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (latch_load),
        .din    (irdata),
        .sel_hi (phys_hi),
        .half   (latch_half)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    // next-state logic
    always_comb begin
        st_nxt = st;
        if (wr32 || rd32) begin
            st_nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (wr16)      st_nxt = ST_WR_HALF;
                    else if (rd16) st_nxt = ST_RD_HALF;
                end
                ST_WR_HALF: begin
                    if (wr16 && same_word) st_nxt = ST_IDLE;
                    else if (rd16)         st_nxt = ST_RD_HALF;
                end
                ST_RD_HALF: begin
                    if (rd16 && same_word) st_nxt = ST_IDLE;
                    else if (wr16)         st_nxt = ST_WR_HALF;
                end
                default: st_nxt = ST_IDLE;
            endcase
        end
    end

    // output and datapath control
    always_comb begin
        iwr         = 1'b0;
        ird         = 1'b0;
        stage_load  = 1'b0;
        latch_load  = 1'b0;
        serve_latch = 1'b0;
        serve_bad   = 1'b0;
        iaddr       = haddr[ADDR_W-1:2];
        iwdata      = mode32 ? hwdata : merged;
        unique case (st)
            ST_WR_HALF: begin
                if (wr16 && same_word) iwr = opp_half;
                else if (wr16)         stage_load = 1'b1;
                if (rd16) begin
                    ird        = 1'b1;
                    latch_load = 1'b1;
                end
            end
            ST_RD_HALF: begin
                if (rd16 && same_word) begin
                    serve_latch = opp_half;
                    serve_bad   = !opp_half;
                end else if (rd16) begin
                    ird        = 1'b1;
                    latch_load = 1'b1;
                end
                if (wr16) stage_load = 1'b1;
            end
            default: begin
                stage_load = wr16;
                ird        = rd16;
                latch_load = rd16;
            end
        endcase
        if (wr32) iwr = 1'b1;
        if (rd32) ird = 1'b1;
        pend_load = stage_load || latch_load;
    end

    always_comb begin
        fresh_half = phys_hi ? irdata[DATA_W-1:HALF_W] : irdata[HALF_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_addr <= '0;
            pend_hi   <= 1'b0;
        end else if (pend_load) begin
            pend_addr <= haddr[ADDR_W-1:2];
            pend_hi   <= phys_hi;
        end
    end

    // registered host read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hrdata    <= '0;
            hrdata_oe <= 2'b00;
        end else if (rd32) begin
            hrdata    <= irdata;
            hrdata_oe <= 2'b11;
        end else if (rd16) begin
            hrdata_oe <= 2'b01;
            if (serve_latch)    hrdata <= {{HALF_W{1'b0}}, latch_half};
            else if (serve_bad) hrdata <= '0;
            else                hrdata <= {{HALF_W{1'b0}}, fresh_half};
        end else begin
            hrdata    <= '0;
            hrdata_oe <= 2'b00;
        end
    end
endmodule

// File: rtl/hbw_word_pair_chk.sv
module hbw_word_pair_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                mode32,
    input logic                hcs,
    input logic                hwr,
    input logic                hrd,
    input logic                iwr,
    input logic                ird,
    input logic [1:0]          hrdata_oe,
    input hbw_pkg::hbw_state_e st
);
    import hbw_pkg::*;

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(iwr && ird));

    // R10
    quiet_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hcs |-> (!iwr && !ird));

    // R2
    commit_from_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iwr && !mode32) |-> (st == ST_WR_HALF));

    // R2
    commit_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iwr && !mode32) |=> (st == ST_IDLE));

    // R9
    upper_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hrdata_oe[1] |-> $past(mode32));

    // R9
    half_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ird && !mode32) |=> (hrdata_oe == 2'b01));

    // R9
    oe_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hrdata_oe != 2'b00) |-> $past(hcs && hrd && !hwr));
endmodule

bind hbw_word_pair hbw_word_pair_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode32    (mode32),
    .hcs       (hcs),
    .hwr       (hwr),
    .hrd       (hrd),
    .iwr       (iwr),
    .ird       (ird),
    .hrdata_oe (hrdata_oe),
    .st        (st)
);

// File: tb/tb_hbw_word_pair.sv
module tb_hbw_word_pair;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode32 = 1'b0;
    logic [31:0]   swap_cfg = 32'h0;
    logic          hcs = 1'b0, hwr = 1'b0, hrd = 1'b0;
    logic [AW-1:1] haddr = '0;
    logic [31:0]   hwdata = '0;
    logic [31:0]   hrdata;
    logic [1:0]    hrdata_oe;
    logic          iwr, ird;
    logic [AW-3:0] iaddr;
    logic [31:0]   iwdata;
    logic [31:0]   irdata;
    logic [31:0]   salt = 32'h0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int          m_kind = 0;   // 0 none, 1 write half pending, 2 read half pending
    int          m_addr = 0;
    int          m_hi = 0;
    logic [15:0] m_stage = '0;
    logic [31:0] m_latch = '0;
    logic [31:0] exp_hr = '0;
    logic [1:0]  exp_oe = '0;

    always #5 clk = ~clk;

    // internal storage stub: data depends on word address and a bench salt
    assign irdata = {8'hC3 ^ {2'b00, iaddr}, 8'h5A, ~{2'b00, iaddr}, {2'b00, iaddr}} ^ salt;

    hbw_word_pair #(.ADDR_W(AW), .DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .swap_cfg(swap_cfg),
        .hcs(hcs), .hwr(hwr), .hrd(hrd), .haddr(haddr), .hwdata(hwdata),
        .hrdata(hrdata), .hrdata_oe(hrdata_oe), .iwr(iwr), .ird(ird),
        .iaddr(iaddr), .iwdata(iwdata), .irdata(irdata)
    );

    function automatic logic [31:0] word_at(int wa);
        logic [7:0] b;
        b = 8'(wa);
        return {8'hC3 ^ b, 8'h5A, ~b, b} ^ salt;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one host cycle; entered and left just after a falling edge
    task automatic step(input string tag, input logic cs, input logic wr, input logic rd,
                        input int byte_addr, input logic [31:0] d);
        int wa, h;
        logic e_iwr, e_ird;
        logic [31:0] e_wd, rw;
        hcs = cs; hwr = wr; hrd = rd;
        haddr = AW'(byte_addr) >> 1;
        hwdata = d;
        #1;
        wa = byte_addr >> 2;
        h = int'(byte_addr[1]) ^ int'(!mode32 && swap_cfg == 32'hFFFF_FFFF);
        rw = word_at(wa);
        e_iwr = 0; e_ird = 0; e_wd = '0;
        exp_hr = '0; exp_oe = 2'b00;
        if (cs && wr) begin
            if (mode32) begin
                e_iwr = 1; e_wd = d; m_kind = 0;
            end else if (m_kind == 1 && m_addr == wa) begin
                if (m_hi != h) begin
                    e_iwr = 1;
                    e_wd = (h != 0) ? {d[15:0], m_stage} : {m_stage, d[15:0]};
                end
                m_kind = 0;
            end else begin
                m_kind = 1; m_addr = wa; m_hi = h; m_stage = d[15:0];
            end
        end else if (cs && rd) begin
            if (mode32) begin
                e_ird = 1; exp_hr = rw; exp_oe = 2'b11; m_kind = 0;
            end else if (m_kind == 2 && m_addr == wa) begin
                exp_oe = 2'b01;
                if (m_hi != h) exp_hr = (h != 0) ? {16'h0, m_latch[31:16]} : {16'h0, m_latch[15:0]};
                m_kind = 0;
            end else begin
                e_ird = 1; m_latch = rw; exp_oe = 2'b01;
                exp_hr = (h != 0) ? {16'h0, rw[31:16]} : {16'h0, rw[15:0]};
                m_kind = 2; m_addr = wa; m_hi = h;
            end
        end
        chk(tag, "iwr", 32'(iwr), 32'(e_iwr));
        chk(tag, "ird", 32'(ird), 32'(e_ird));
        if (e_iwr) chk(tag, "iwdata", iwdata, e_wd);
        if (e_iwr || e_ird) chk(tag, "iaddr", 32'(iaddr), 32'(wa));
        @(posedge clk);
        @(negedge clk);
        chk(tag, "hrdata_oe", 32'(hrdata_oe), 32'(exp_oe));
        chk(tag, "hrdata", hrdata, exp_hr);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1", "iwr", 32'(iwr), 0);
        chk("R1", "ird", 32'(ird), 0);
        chk("R1", "hrdata_oe", 32'(hrdata_oe), 0);
        chk("R1", "hrdata", hrdata, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "hrdata_oe after release", 32'(hrdata_oe), 0);

        // R2: low then high, then high then low
        step("R2", 1, 1, 0, 8'h10, 32'h0000_1111);
        step("R2", 1, 1, 0, 8'h12, 32'h0000_2222);
        step("R2", 1, 1, 0, 8'h16, 32'h0000_AAAA);
        step("R2", 1, 1, 0, 8'h14, 32'h0000_BBBB);

        // R3: same half twice discards, then a fresh pair completes
        step("R3", 1, 1, 0, 8'h18, 32'h0000_3333);
        step("R3", 1, 1, 0, 8'h18, 32'h0000_4444);
        step("R3", 1, 1, 0, 8'h1A, 32'h0000_5555);
        step("R3", 1, 1, 0, 8'h18, 32'h0000_6666);

        // R4: word change drops pending half
        step("R4", 1, 1, 0, 8'h20, 32'h0000_7777);
        step("R4", 1, 1, 0, 8'h26, 32'h0000_8888);
        step("R4", 1, 1, 0, 8'h24, 32'h0000_9999);
        // R4: a read drops a pending write half
        step("R4", 1, 1, 0, 8'h28, 32'h0000_1234);
        step("R4", 1, 0, 1, 8'h28, 32'h0);
        step("R4", 1, 1, 0, 8'h2A, 32'h0000_5678);

        // R10: deselected cycles keep the pending half
        step("R10", 1, 1, 0, 8'h30, 32'h0000_C0DE);
        step("R10", 0, 1, 0, 8'h32, 32'h0000_DEAD);
        step("R10", 0, 0, 1, 8'h40, 32'h0);
        step("R10", 1, 1, 0, 8'h32, 32'h0000_F00D);

        // R5: second half served from latch even after storage changes
        step("R5", 1, 0, 1, 8'h34, 32'h0);
        salt = 32'h1357_9BDF;
        step("R5", 1, 0, 1, 8'h36, 32'h0);
        step("R5", 1, 0, 1, 8'h3A, 32'h0);
        salt = 32'h0;
        step("R5", 1, 0, 1, 8'h38, 32'h0);

        // R6: repeated half invalid, next read restarts
        step("R6", 1, 0, 1, 8'h3E, 32'h0);
        step("R6", 1, 0, 1, 8'h3E, 32'h0);
        step("R6", 1, 0, 1, 8'h3C, 32'h0);
        step("R6", 1, 0, 1, 8'h3E, 32'h0);

        // R7: swap active at all-ones only
        swap_cfg = 32'hFFFF_FFFF;
        step("R7", 1, 1, 0, 8'h44, 32'h0000_AB01);
        step("R7", 1, 1, 0, 8'h46, 32'h0000_CD02);
        step("R7", 1, 0, 1, 8'h48, 32'h0);
        step("R7", 1, 0, 1, 8'h4A, 32'h0);
        swap_cfg = 32'hFFFF_FFFE;
        step("R7", 1, 1, 0, 8'h4C, 32'h0000_EF03);
        step("R7", 1, 1, 0, 8'h4E, 32'h0000_1204);

        // R8/R9: 32-bit mode ignores swap, full word each access
        swap_cfg = 32'hFFFF_FFFF;
        mode32 = 1'b1;
        step("R8", 1, 1, 0, 8'h50, 32'hDEAD_BEEF);
        step("R8", 1, 0, 1, 8'h54, 32'h0);
        step("R9", 1, 0, 1, 8'h5A, 32'h0);
        // R8: a 32-bit access clears a pending 16-bit half
        mode32 = 1'b0;
        step("R8", 1, 1, 0, 8'h60, 32'h0000_4321);
        mode32 = 1'b1;
        step("R8", 1, 1, 0, 8'h64, 32'h0BAD_CAFE);
        mode32 = 1'b0;
        step("R8", 1, 1, 0, 8'h62, 32'h0000_8765);
        step("R9", 0, 0, 0, 8'h00, 32'h0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule